// File: doc/BRIEF.md
# Load-Use Stall Controller

This block decides, once per cycle, whether a five-stage in-order pipeline with full result bypassing must freeze its front end for one cycle. It looks at two instructions: the one in the execute stage and the one in the decode stage right behind it. If the execute-stage instruction reads data memory, its result is not available until after the memory stage. The bypass network therefore cannot deliver that value to an instruction that needs it in the very next execute cycle. The block detects this case and opens a one-cycle gap.

On a stall, the block lowers the program-counter write enable and the fetch/decode register write enable, so the same instruction is fetched and decoded again. It also raises a control-clear signal. The surrounding pipeline uses that signal to load all-zero control fields into the decode/execute register, which turns the next execute slot into a bubble. One cycle later the load has moved to the memory stage, and the bypass from the memory/write-back register supplies its data. Every other producer-consumer distance is left to forwarding.

A small two-state machine sits behind the comparators. State FLOW is the normal state. A detected hazard in FLOW raises the stall and moves the machine to HOLD. HOLD always returns to FLOW after one cycle and never stalls. This guarantees that each load-use pair costs exactly one bubble. FLOW stays in FLOW when there is no hazard. While reset is asserted the machine is held in FLOW and no stall is raised.

Top module: `load_use_guard`

## Requirements
- R1: While rst_n is low, pc_we and ifid_we are 1 and ctrl_clr is 0, whatever the other inputs are.
- R2: With ex_is_load = 1 and ex_dst equal to a nonzero id_src_a, the block stalls in that same cycle: pc_we = 0, ifid_we = 0, ctrl_clr = 1.
- R3: With ex_is_load = 1 and ex_dst equal to a nonzero id_src_b, the block stalls in that same cycle.
- R4: When ex_dst matches both id_src_a and id_src_b, the result is a single ordinary stall, identical to R2.
- R5: When ex_dst is register 0, no stall is raised, even when the decode operands are also 0.
- R6: When ex_is_load = 0 (an ALU producer), no stall is raised, whatever the register numbers are.
- R7: When ex_dst matches neither decode operand, no stall is raised.
- R8: The cycle after a stall never stalls, even if the inputs still describe a hazard. Each load-use pair therefore costs exactly one bubble, and a persisting hazard stalls on alternate cycles.
- R9: pc_we and ifid_we are always equal, and ctrl_clr is always their complement.
- R10: In a pipeline that advances instructions from decode to execute, an instruction that reads a loaded register two or more slots after the load causes no stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_src_a | input | AW (5) | First source register number of the decode-stage instruction |
| id_src_b | input | AW (5) | Second source register number of the decode-stage instruction |
| ex_dst | input | AW (5) | Load destination register number (rt field) of the execute-stage instruction |
| ex_is_load | input | 1 | Memory-read control bit of the execute-stage instruction |
| pc_we | output | 1 | Program counter write enable, 0 during a stall |
| ifid_we | output | 1 | Fetch/decode pipeline register write enable, 0 during a stall |
| ctrl_clr | output | 1 | Clear the control fields written into the decode/execute register, 1 during a stall |

## Verification
The assertions assume that the inputs come from a real pipeline. In particular, after a stall the execute slot holds the bubble, so any hazard the inputs still show in the HOLD cycle is stale. The assertions also assume that register 0 is never a real load target. The directed tasks hold the inputs steady across clock edges and change them only mid-cycle. One task deliberately keeps a hazard present for several cycles to show the alternating pattern of R8. The pipeline-model task moves instructions from decode to execute exactly as the stall outputs command, so the distance-two and ALU-producer cases arise as they would in a real pipeline.

// File: rtl/load_use_guard_pkg.sv
package load_use_guard_pkg;
    // FLOW: normal issue; HOLD: cycle following a stall, bubble in execute
    typedef enum logic [0:0] {
        ST_FLOW = 1'b0,
        ST_HOLD = 1'b1
    } guard_state_e;

    localparam int NUM_SRC = 2;
endpackage

// File: rtl/load_use_match.sv
module load_use_match #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    output logic          hit
);
    // register 0 is hard-wired and is never a real dependence
    always_comb begin
        hit = (src == dst) && (dst != '0);
    end
endmodule

// File: rtl/load_use_fsm.sv
module load_use_fsm
    import load_use_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hazard,
    output logic stall
);
    guard_state_e state_q;
    guard_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FLOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FLOW: if (hazard) state_d = ST_HOLD;
            ST_HOLD: state_d = ST_FLOW;
            default: state_d = ST_FLOW;
        endcase
    end

    always_comb begin
        stall = 1'b0;
        unique case (state_q)
            ST_FLOW: stall = hazard && rst_n;
            ST_HOLD: stall = 1'b0;
            default: stall = 1'b0;
        endcase
    end
endmodule

// File: rtl/load_use_guard.sv
module load_use_guard
    import load_use_guard_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] id_src_a,
    input  logic [AW-1:0] id_src_b,
    input  logic [AW-1:0] ex_dst,
    input  logic          ex_is_load,
    output logic          pc_we,
    output logic          ifid_we,
    output logic          ctrl_clr
);
    logic [NUM_SRC-1:0][AW-1:0] srcs;
    logic [NUM_SRC-1:0]         hits;
    logic                       hazard;
    logic                       stall;

    assign srcs[0] = id_src_a;
    assign srcs[1] = id_src_b;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
        load_use_match #(.AW(AW)) u_match (
            .src (srcs[g]),
            .dst (ex_dst),
            .hit (hits[g])
        );
    end

    assign hazard = ex_is_load && (|hits);

    load_use_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .hazard (hazard),
        .stall  (stall)
    );

    assign pc_we    = !stall;
    assign ifid_we  = !stall;
    assign ctrl_clr = stall;
endmodule

// File: rtl/load_use_guard_chk.sv
module load_use_guard_chk #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] id_src_a,
    input logic [AW-1:0] id_src_b,
    input logic [AW-1:0] ex_dst,
    input logic          ex_is_load,
    input logic          pc_we,
    input logic          ifid_we,
    input logic          ctrl_clr
);
    logic prev_clr;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_clr <= 1'b0;
        else        prev_clr <= ctrl_clr;
    end

    // R1
    always @(negedge clk) begin
        if (rst_n === 1'b0) begin
            reset_quiet_chk: assert (pc_we && ifid_we && !ctrl_clr);
        end
    end

    // R2
    use_a_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_is_load && ex_dst != '0 && ex_dst == id_src_a && !prev_clr) |-> ctrl_clr);

    // R3
    use_b_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_is_load && ex_dst != '0 && ex_dst == id_src_b && !prev_clr) |-> ctrl_clr);

    // R5
    zero_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_dst == '0) |-> !ctrl_clr);

    // R6
    alu_producer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_is_load |-> !ctrl_clr);

    // R7
    no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_dst != id_src_a && ex_dst != id_src_b) |-> !ctrl_clr);

    // R8
    one_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_clr |=> !ctrl_clr);

    // R9
    enables_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we == ifid_we) && (ctrl_clr != pc_we));
endmodule

bind load_use_guard load_use_guard_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .id_src_a   (id_src_a),
    .id_src_b   (id_src_b),
    .ex_dst     (ex_dst),
    .ex_is_load (ex_is_load),
    .pc_we      (pc_we),
    .ifid_we    (ifid_we),
    .ctrl_clr   (ctrl_clr)
);

// File: tb/load_use_guard_bench.sv
module load_use_guard_bench;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] id_src_a = '0;
    logic [AW-1:0] id_src_b = '0;
    logic [AW-1:0] ex_dst = '0;
    logic          ex_is_load = 1'b0;
    logic          pc_we;
    logic          ifid_we;
    logic          ctrl_clr;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    load_use_guard #(.AW(AW)) u_load_use_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .id_src_a   (id_src_a),
        .id_src_b   (id_src_b),
        .ex_dst     (ex_dst),
        .ex_is_load (ex_is_load),
        .pc_we      (pc_we),
        .ifid_we    (ifid_we),
        .ctrl_clr   (ctrl_clr)
    );

    // drive mid-cycle, sample 1 ns later, well before the next rising edge
    task automatic drive(input logic [AW-1:0] a, input logic [AW-1:0] b,
                         input logic [AW-1:0] d, input logic ld);
        @(negedge clk);
        id_src_a = a; id_src_b = b; ex_dst = d; ex_is_load = ld;
        #1;
    endtask

    task automatic expect_stall(input string tag, input logic exp);
        logic [2:0] act;
        logic [2:0] want;
        act  = {pc_we, ifid_we, ctrl_clr};
        want = {!exp, !exp, exp};
        n_run++;
        if (act !== want) begin
            n_fail++;
            $display("FAIL %s: pc_we/ifid_we/ctrl_clr actual %b expected %b", tag, act, want);
        end
    endtask

    task automatic idle();
        drive(5'd0, 5'd0, 5'd0, 1'b0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        drive(5'd4, 5'd4, 5'd4, 1'b1);
        expect_stall("R1 hazard inputs under reset", 1'b0);
        drive(5'd4, 5'd4, 5'd4, 1'b1);
        expect_stall("R1 second reset cycle", 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        idle();
        expect_stall("R1 idle after release", 1'b0);
    endtask

    task automatic t_basic_matches();
        idle();
        drive(5'd7, 5'd2, 5'd7, 1'b1);
        expect_stall("R2 load dst equals src_a", 1'b1);
        idle();
        drive(5'd3, 5'd9, 5'd9, 1'b1);
        expect_stall("R3 load dst equals src_b", 1'b1);
        idle();
        drive(5'd31, 5'd31, 5'd31, 1'b1);
        expect_stall("R4 load dst equals both sources", 1'b1);
        idle();
        expect_stall("R9 enables restored after stall", 1'b0);
    endtask

    task automatic t_no_stall_cases();
        idle();
        drive(5'd0, 5'd0, 5'd0, 1'b1);
        expect_stall("R5 load to register 0", 1'b0);
        drive(5'd6, 5'd6, 5'd6, 1'b0);
        expect_stall("R6 ALU producer match", 1'b0);
        drive(5'd1, 5'd2, 5'd3, 1'b1);
        expect_stall("R7 load no match", 1'b0);
        drive(5'd16, 5'd8, 5'd24, 1'b1);
        expect_stall("R7 load partial bit overlap", 1'b0);
    endtask

    task automatic t_one_bubble();
        idle();
        drive(5'd12, 5'd0, 5'd12, 1'b1);
        expect_stall("R8 first hazard cycle stalls", 1'b1);
        drive(5'd12, 5'd0, 5'd12, 1'b1);
        expect_stall("R8 following cycle released", 1'b0);
        drive(5'd12, 5'd0, 5'd12, 1'b1);
        expect_stall("R8 persisting hazard stalls again", 1'b1);
        idle();
    endtask

    // pipeline model: moves decode into execute unless the block stalls
    task automatic t_pipeline();
        localparam int N = 7;
        logic          p_ld  [N];
        logic [AW-1:0] p_dst [N];
        logic [AW-1:0] p_a   [N];
        logic [AW-1:0] p_b   [N];
        int id_idx;
        int ex_idx;
        int stalls;
        int stall_at;
        // 0 load r3; 1 uses r3 (stall); 2 load r7; 3 unrelated;
        // 4 uses r7 two behind; 5 ALU writes r4; 6 uses r4
        p_ld  = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
        p_dst = '{5'd3, 5'd5, 5'd7, 5'd2, 5'd8, 5'd4, 5'd6};
        p_a   = '{5'd1, 5'd3, 5'd1, 5'd1, 5'd7, 5'd2, 5'd4};
        p_b   = '{5'd0, 5'd1, 5'd0, 5'd1, 5'd0, 5'd2, 5'd0};
        id_idx = 0; ex_idx = -1; stalls = 0; stall_at = -1;
        idle();
        while (id_idx < N) begin
            drive(p_a[id_idx], p_b[id_idx],
                  (ex_idx >= 0) ? p_dst[ex_idx] : 5'd0,
                  (ex_idx >= 0) ? p_ld[ex_idx] : 1'b0);
            if (ctrl_clr) begin
                stalls++;
                stall_at = id_idx;
                ex_idx = -1;
            end else begin
                ex_idx = id_idx;
                id_idx++;
            end
        end
        idle();
        n_run++;
        if (stalls != 1 || stall_at != 1) begin
            n_fail++;
            $display("FAIL R10 pipeline stalls actual %0d at %0d expected 1 at 1",
                     stalls, stall_at);
        end
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_basic_matches();
        t_no_stall_cases();
        t_one_bubble();
        t_pipeline();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule